// File: doc/BRIEF.md
# USB Frame Number Tracker

This block holds the current 11-bit frame number and the 3-bit microframe number for a USB peripheral. A token decoder in front of it gives it three one-cycle strobes. The first marks a start-of-frame packet that arrived intact and comes with its frame field. The second marks a start-of-frame packet that arrived damaged. The third marks a microframe start-of-frame packet. A separate interpolation timer also sends a strobe each time a frame is expected, whether or not a packet was seen.

The frame number changes only when an intact start-of-frame packet is received. A damaged or missing packet leaves it unchanged, and the interpolation timer never alters it. The microframe number counts microframe packets and is cleared by every intact frame-level packet. A mode input decides whether the start-of-frame interrupt pulse follows only received packets, or follows the interpolation timer as well. All outputs are registered and change on the clock edge after the strobe that causes them.

Top module: `usb_frame_tracker`

## Requirements
- R1: When `sof_ok_i` is high, `frame_o` shows the value of `sof_frame_i` after the next rising edge. This includes the limits 0 and 2047.
- R2: A `sof_bad_i` strobe on its own changes neither counter and raises no interrupt, whatever the value of `irq_mode_i`.
- R3: An `interp_tick_i` strobe never changes `frame_o`.
- R4: Each `usof_i` strobe without `sof_ok_i` adds one to `uframe_o` on the next edge. The count wraps from 7 to 0.
- R5: `sof_ok_i` clears `uframe_o` to 0 on the next edge. It wins over a `usof_i` strobe in the same cycle.
- R6: With `irq_mode_i` = 0, `sof_irq_o` is high for exactly the one cycle after each `sof_ok_i`, and it is low at every other time.
- R7: With `irq_mode_i` = 1, `sof_irq_o` is high for the one cycle after a `sof_ok_i` or an `interp_tick_i`. When both arrive in the same cycle, there is still a single one-cycle pulse.
- R8: A synchronous `rst` clears `frame_o`, `uframe_o` and `sof_irq_o` to 0 on the next edge. Reset wins over any strobe in the same cycle.
- R9: In a cycle with no strobes, both counters hold and `sof_irq_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_ok_i | input | 1 | Strobe: intact start-of-frame packet received |
| sof_frame_i | input | 11 | Frame field of that packet |
| sof_bad_i | input | 1 | Strobe: damaged start-of-frame packet |
| usof_i | input | 1 | Strobe: microframe start-of-frame packet received |
| interp_tick_i | input | 1 | Strobe from the interpolation timer |
| irq_mode_i | input | 1 | Interrupt mode: 0 = received packets only, 1 = packets and timer |
| frame_o | output | 11 | Current frame number |
| uframe_o | output | 3 | Current microframe number |
| sof_irq_o | output | 1 | One-cycle start-of-frame interrupt pulse |

## Verification
A wrong frame register would show on `frame_o` on the edge right after a strobe. This matters most after a damaged packet or a timer tick, because the value must still equal the last intact frame field at that point. A counting or priority fault in the microframe counter would show on `uframe_o` one edge after a `usof_i`. A wrap fault would appear at the eighth strobe, and a priority fault when `usof_i` and `sof_ok_i` coincide. Interrupt decode faults would show as a missing, extra or stretched pulse on `sof_irq_o` one cycle after the strobe, and only in the mode that exposes them.

// File: rtl/ftrk_pkg.sv
package ftrk_pkg;

    localparam int FRAME_W_DEF  = 11;
    localparam int UFRAME_W_DEF = 3;

    typedef enum logic {
        IRQ_RX_ONLY   = 1'b0,
        IRQ_RX_TIMER  = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic sof_ok;
        logic sof_bad;
        logic usof;
        logic tick;
    } ftrk_evt_t;

    function automatic logic irq_fire(input ftrk_evt_t ev, input irq_mode_e mode);
        return ev.sof_ok || ((mode == IRQ_RX_TIMER) && ev.tick);
    endfunction

endpackage

// File: rtl/ftrk_frame_reg.sv
module ftrk_frame_reg #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/ftrk_uframe_ctr.sv
module ftrk_uframe_ctr #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + ONE;
    end
endmodule

// File: rtl/ftrk_irq_gen.sv
module ftrk_irq_gen
    import ftrk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ftrk_evt_t ev,
    input  irq_mode_e mode,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_fire(ev, mode);
    end
endmodule

// File: rtl/usb_frame_tracker.sv
module usb_frame_tracker
    import ftrk_pkg::*;
#(
    parameter int FRAME_W  = FRAME_W_DEF,
    parameter int UFRAME_W = UFRAME_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sof_ok_i,
    input  logic [FRAME_W-1:0]  sof_frame_i,
    input  logic                sof_bad_i,
    input  logic                usof_i,
    input  logic                interp_tick_i,
    input  logic                irq_mode_i,
    output logic [FRAME_W-1:0]  frame_o,
    output logic [UFRAME_W-1:0] uframe_o,
    output logic                sof_irq_o
);
    ftrk_evt_t ev;
    irq_mode_e mode;

    always_comb begin
        ev.sof_ok  = sof_ok_i;
        ev.sof_bad = sof_bad_i;
        ev.usof    = usof_i;
        ev.tick    = interp_tick_i;
        mode       = irq_mode_e'(irq_mode_i);
    end

    ftrk_frame_reg #(.WIDTH(FRAME_W)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .load (ev.sof_ok),
        .din  (sof_frame_i),
        .q    (frame_o)
    );

    ftrk_uframe_ctr #(.WIDTH(UFRAME_W)) u_uframe (
        .clk   (clk),
        .rst   (rst),
        .clr   (ev.sof_ok),
        .inc   (ev.usof),
        .count (uframe_o)
    );

    ftrk_irq_gen u_irq (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .mode (mode),
        .irq  (sof_irq_o)
    );
endmodule

// File: rtl/ftrk_checker.sv
module ftrk_checker #(
    parameter int FRAME_W  = 11,
    parameter int UFRAME_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                sof_ok_i,
    input logic [FRAME_W-1:0]  sof_frame_i,
    input logic                sof_bad_i,
    input logic                usof_i,
    input logic                interp_tick_i,
    input logic                irq_mode_i,
    input logic [FRAME_W-1:0]  frame_o,
    input logic [UFRAME_W-1:0] uframe_o,
    input logic                sof_irq_o
);
    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        sof_ok_i |=> frame_o == $past(sof_frame_i)); // R1

    AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (sof_bad_i && !sof_ok_i && !usof_i && !interp_tick_i)
        |=> ($stable(frame_o) && $stable(uframe_o) && !sof_irq_o)); // R2

    AST_TICK_HOLDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (interp_tick_i && !sof_ok_i) |=> $stable(frame_o)); // R3

    AST_UFRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (usof_i && !sof_ok_i) |=> uframe_o == UFRAME_W'($past(uframe_o) + 1'b1)); // R4

    AST_UFRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sof_ok_i |=> uframe_o == '0); // R5

    AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!irq_mode_i && !sof_ok_i) |=> !sof_irq_o); // R6

    AST_MODE1_TICK: assert property (@(posedge clk) disable iff (rst)
        (irq_mode_i && interp_tick_i) |=> sof_irq_o); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (frame_o == '0 && uframe_o == '0 && !sof_irq_o)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sof_ok_i && !usof_i && !interp_tick_i)
        |=> ($stable(frame_o) && $stable(uframe_o) && !sof_irq_o)); // R9
endmodule

bind usb_frame_tracker ftrk_checker #(.FRAME_W(FRAME_W), .UFRAME_W(UFRAME_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sof_ok_i      (sof_ok_i),
    .sof_frame_i   (sof_frame_i),
    .sof_bad_i     (sof_bad_i),
    .usof_i        (usof_i),
    .interp_tick_i (interp_tick_i),
    .irq_mode_i    (irq_mode_i),
    .frame_o       (frame_o),
    .uframe_o      (uframe_o),
    .sof_irq_o     (sof_irq_o)
);

// File: tb/usb_frame_tracker_tb.sv
module usb_frame_tracker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_ok_i = 1'b0;
    logic [10:0] sof_frame_i = '0;
    logic        sof_bad_i = 1'b0;
    logic        usof_i = 1'b0;
    logic        interp_tick_i = 1'b0;
    logic        irq_mode_i = 1'b0;
    logic [10:0] frame_o;
    logic [2:0]  uframe_o;
    logic        sof_irq_o;

    always #4 clk = ~clk;

    usb_frame_tracker u_dut (
        .clk(clk), .rst(rst), .sof_ok_i(sof_ok_i), .sof_frame_i(sof_frame_i),
        .sof_bad_i(sof_bad_i), .usof_i(usof_i), .interp_tick_i(interp_tick_i),
        .irq_mode_i(irq_mode_i), .frame_o(frame_o), .uframe_o(uframe_o),
        .sof_irq_o(sof_irq_o)
    );

    typedef struct {
        logic [10:0] frame;
        logic [2:0]  uf;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [10:0] m_frame  = '0;
    logic [2:0]  m_uf     = '0;
    bit          done     = 0;

    task automatic drive(input bit r, input bit ok, input logic [10:0] fr,
                         input bit bad, input bit us, input bit tk,
                         input bit md, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; sof_ok_i = ok; sof_frame_i = fr; sof_bad_i = bad;
        usof_i = us; interp_tick_i = tk; irq_mode_i = md;
        if (r) begin
            m_frame = '0; m_uf = '0; e.irq = 1'b0;
        end else begin
            if (ok) begin m_frame = fr; m_uf = '0; end
            else if (us) m_uf = m_uf + 3'd1;
            e.irq = ok | (md & tk);
        end
        e.frame = m_frame; e.uf = m_uf; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (frame_o !== e.frame || uframe_o !== e.uf || sof_irq_o !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: got frame=%0h uframe=%0d irq=%0b, expected frame=%0h uframe=%0d irq=%0b",
                             e.tag, frame_o, uframe_o, sof_irq_o, e.frame, e.uf, e.irq);
                end
            end
        end
    end

    initial begin : stimulus
        drive(1, 0, 11'h000, 0, 0, 0, 0, "R8 reset state");
        drive(1, 0, 11'h000, 0, 0, 0, 0, "R8 reset state");
        drive(0, 0, 11'h000, 0, 0, 0, 0, "R9 idle after reset");
        drive(0, 1, 11'h123, 0, 0, 0, 0, "R1 R6 valid sof load");
        drive(0, 0, 11'h000, 0, 0, 0, 0, "R6 R9 pulse ends");
        for (int i = 0; i < 9; i++)
            drive(0, 0, 11'h000, 0, 1, 0, 0, "R4 uframe count and wrap");
        drive(0, 0, 11'h555, 0, 0, 1, 0, "R3 R6 tick mode0 no irq");
        drive(0, 0, 11'h2AA, 1, 0, 0, 0, "R2 bad sof mode0");
        drive(0, 0, 11'h2AA, 1, 0, 0, 1, "R2 bad sof mode1");
        drive(0, 0, 11'h3FF, 0, 0, 1, 1, "R3 R7 tick mode1 irq");
        drive(0, 0, 11'h000, 0, 0, 0, 1, "R9 idle mode1");
        drive(0, 0, 11'h000, 0, 1, 0, 1, "R4 usof step");
        drive(0, 1, 11'h045, 0, 1, 0, 0, "R5 sof beats usof");
        drive(0, 0, 11'h000, 0, 1, 0, 0, "R4 usof after clear");
        drive(0, 0, 11'h000, 0, 1, 0, 0, "R4 usof after clear");
        drive(0, 1, 11'h7FF, 0, 0, 0, 0, "R1 R5 max frame");
        drive(0, 1, 11'h000, 0, 0, 1, 1, "R1 R7 sof with tick single pulse");
        drive(0, 0, 11'h000, 0, 0, 1, 1, "R7 tick after sof");
        drive(0, 0, 11'h000, 0, 1, 0, 1, "R4 usof");
        drive(0, 1, 11'h321, 0, 0, 0, 1, "R1 R7 sof mode1");
        drive(1, 1, 11'h7AB, 0, 1, 1, 1, "R8 reset beats strobes");
        drive(0, 0, 11'h000, 0, 0, 0, 0, "R8 R9 hold after reset");
        @(negedge clk);
        rst = 0; sof_ok_i = 0; usof_i = 0; interp_tick_i = 0; sof_bad_i = 0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule